// File: doc/BRIEF.md
# MSI Interrupt Remapping Translator

This block sits on the path of message-signalled interrupts between devices and the interrupt fabric. Each incoming message (a 64-bit address and a 32-bit data word) is classified. When remapping is switched off, or the message uses the legacy compatibility layout, it is forwarded untouched. When the message is in remappable layout, the block works out a table index from the address and, optionally, the data word. It then asks an external entry validator for that table entry. From the returned entry it rebuilds a compatibility-layout message. A malformed request, or an entry the validator reports as faulty, causes the interrupt to be dropped and an error to be flagged on the result.

Requests enter on a valid/ready port and results leave on a valid/ready port. The block holds one message at a time. `in_ready` is high only while nothing is in flight. A result stays on `res_*` until `res_ready` is seen high at a clock edge, so a stalled consumer also stalls intake. The lookup request is a valid/ready pair. The validator answers with exactly one `ent_valid` pulse per accepted request. `remap_on` is a plain level that is sampled when a request is accepted.

Top module: `msi_remap_xlate`

## Requirements
- R1: When `remap_on` is 0 at acceptance, the result address and data equal the input and the error flag is 0; no lookup is issued.
- R2: With remapping on, a nonzero input address bits 63:32 gives an error result and no lookup.
- R3: With remapping on, input address bits 31:20 other than 0xFEE give an error result and no lookup.
- R4: With remapping on and a well-formed head, input address bit 4 = 0 (compatibility layout) passes the message through unchanged with no error and no lookup.
- R5: In remappable layout, exactly one lookup is issued with index = {addr[2], addr[19:5]} (16 bits) when subhandle-valid (addr bit 3) is 0; the data word is then ignored.
- R6: When addr bit 3 is 1, the index is {addr[2], addr[19:5]} plus data[15:0], wrapping modulo 2^16.
- R7: When addr bit 3 is 1 and data[31:16] is nonzero, the result is an error and no lookup is issued.
- R8: A lookup answered with the fault flag gives an error result.
- R9: A remapped address has bits 63:40 = destination 31:8, bits 39:32 = 0, bits 31:20 = 0xFEE, bits 19:12 = destination 7:0, bits 11:4 = 0, bit 3 = redirection hint, bit 2 = destination mode, and bits 1:0 copied from the input address.
- R10: Remapped data has bits 7:0 = vector, bits 10:8 = delivery mode, bit 14 = 1, bit 15 = trigger mode, and all other bits 0.
- R11: After reset `in_ready` is 1 and `res_valid` and `ent_req_valid` are 0; `in_ready` is 0 while a message is in flight. A result with `res_ready` low holds its valid flag, address, data and error flag unchanged, and a pending lookup request holds its index.
- R12: An error result carries address 0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap_on | input | 1 | Remapping enable, sampled at acceptance |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request ready (idle) |
| in_addr | input | 64 | Request message address |
| in_data | input | 32 | Request message data |
| ent_req_valid | output | 1 | Table lookup request valid |
| ent_req_ready | input | 1 | Validator accepts lookup |
| ent_req_index | output | 16 | Table index to look up |
| ent_valid | input | 1 | Lookup response pulse |
| ent_fault | input | 1 | Entry fault (present, reserved or source check failed) |
| ent_dest | input | 32 | Entry destination |
| ent_vector | input | 8 | Entry vector |
| ent_dlv_mode | input | 3 | Entry delivery mode |
| ent_trig | input | 1 | Entry trigger mode |
| ent_dest_mode | input | 1 | Entry destination mode |
| ent_redir | input | 1 | Entry redirection hint |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_addr | output | 64 | Result address |
| res_data | output | 32 | Result data |
| res_err | output | 1 | Result is an error (interrupt dropped) |

## Verification
The bench targets index building at its edges. These are a set high index bit, a subhandle that wraps the sum past 0xFFFF to zero, and nonzero upper data bits that must be ignored without a subhandle yet rejected with one. A design that got these wrong would look up the wrong entry, and that would show up both in the lookup index and in the rebuilt destination. It also sends messages that bypass remapping (switched off, legacy layout) carrying addresses that would be illegal if decoded. A design that checked format before the enable would then raise a false error. Fault responses and format errors check that dropped interrupts come out zeroed and flagged. The result port is stalled on a regular pattern, so a design that lets the result change before it is consumed would deliver a corrupted or duplicated message.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;
  localparam int ADDR_W   = 64;
  localparam int DATA_W   = 32;
  localparam int LOIDX_W  = 15;
  localparam int IDX_W    = LOIDX_W + 1;
  localparam int SUB_W    = 16;
  localparam int DEST_W   = 32;
  localparam int VEC_W    = 8;
  localparam int DLV_W    = 3;
  localparam logic [11:0] MSI_HEAD = 12'hFEE;

  // Field positions of a remappable request address
  localparam int A_LOIDX_LSB = 5;
  localparam int A_FMT       = 4;
  localparam int A_SHV       = 3;
  localparam int A_HIIDX     = 2;

  typedef enum logic [1:0] {
    CLS_PASS  = 2'd0,
    CLS_ERR   = 2'd1,
    CLS_REMAP = 2'd2
  } req_cls_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vector;
    logic [DLV_W-1:0]  dlv_mode;
    logic              trig;
    logic              dest_mode;
    logic              redir;
  } entry_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LKREQ = 2'd1,
    ST_LKWT  = 2'd2,
    ST_OUT   = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/msi_req_decode.sv
module msi_req_decode
  import msi_remap_pkg::*;
(
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output req_cls_e          cls,
  output logic [IDX_W-1:0]  index,
  output logic [1:0]        low_bits
);
  logic              upper_nz;
  logic              head_bad;
  logic              remap_fmt;
  logic              sub_valid;
  logic              data_rsvd_nz;
  logic [IDX_W-1:0]  base_idx;
  logic [IDX_W-1:0]  sub_add;

  assign upper_nz     = |addr[ADDR_W-1:32];
  assign head_bad     = addr[31:20] != MSI_HEAD;
  assign remap_fmt    = addr[A_FMT];
  assign sub_valid    = addr[A_SHV];
  assign data_rsvd_nz = |data[DATA_W-1:SUB_W];
  assign base_idx     = {addr[A_HIIDX], addr[A_LOIDX_LSB +: LOIDX_W]};
  assign sub_add      = sub_valid ? data[SUB_W-1:0] : '0;
  assign index        = base_idx + sub_add;
  assign low_bits     = addr[1:0];

  always_comb begin
    if (!enable)                          cls = CLS_PASS;
    else if (upper_nz || head_bad)        cls = CLS_ERR;
    else if (!remap_fmt)                  cls = CLS_PASS;
    else if (sub_valid && data_rsvd_nz)   cls = CLS_ERR;
    else                                  cls = CLS_REMAP;
  end
endmodule

// File: rtl/msi_msg_build.sv
module msi_msg_build
  import msi_remap_pkg::*;
(
  input  entry_t            ent,
  input  logic [1:0]        low_bits,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    addr          = '0;
    addr[63:40]   = ent.dest[DEST_W-1:8];
    addr[31:20]   = MSI_HEAD;
    addr[19:12]   = ent.dest[7:0];
    addr[3]       = ent.redir;
    addr[2]       = ent.dest_mode;
    addr[1:0]     = low_bits;

    data          = '0;
    data[7:0]     = ent.vector;
    data[10:8]    = ent.dlv_mode;
    data[14]      = 1'b1;
    data[15]      = ent.trig;
  end
endmodule

// File: rtl/msi_remap_ctrl.sv
module msi_remap_ctrl
  import msi_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  req_cls_e          dec_cls,
  input  logic [IDX_W-1:0]  dec_index,
  input  logic [1:0]        dec_low,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              rsp_valid,
  input  logic              rsp_fault,
  input  logic [ADDR_W-1:0] built_addr,
  input  logic [DATA_W-1:0] built_data,
  output logic [1:0]        held_low,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);
  ctrl_st_e          st;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        low_q;

  assign in_ready  = st == ST_IDLE;
  assign lk_valid  = st == ST_LKREQ;
  assign res_valid = st == ST_OUT;
  assign lk_index  = idx_q;
  assign held_low  = low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx_q    <= '0;
      low_q    <= '0;
      res_addr <= '0;
      res_data <= '0;
      res_err  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (in_valid) begin
          unique case (dec_cls)
            CLS_PASS: begin
              res_addr <= in_addr;
              res_data <= in_data;
              res_err  <= 1'b0;
              st       <= ST_OUT;
            end
            CLS_ERR: begin
              res_addr <= '0;
              res_data <= '0;
              res_err  <= 1'b1;
              st       <= ST_OUT;
            end
            default: begin
              idx_q <= dec_index;
              low_q <= dec_low;
              st    <= ST_LKREQ;
            end
          endcase
        end
        ST_LKREQ: if (lk_ready) st <= ST_LKWT;
        ST_LKWT: if (rsp_valid) begin
          if (rsp_fault) begin
            res_addr <= '0;
            res_data <= '0;
            res_err  <= 1'b1;
          end else begin
            res_addr <= built_addr;
            res_data <= built_data;
            res_err  <= 1'b0;
          end
          st <= ST_OUT;
        end
        default: if (res_ready) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_remap_xlate.sv
module msi_remap_xlate
  import msi_remap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        remap_on,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_addr,
  input  logic [31:0] in_data,
  output logic        ent_req_valid,
  input  logic        ent_req_ready,
  output logic [15:0] ent_req_index,
  input  logic        ent_valid,
  input  logic        ent_fault,
  input  logic [31:0] ent_dest,
  input  logic [7:0]  ent_vector,
  input  logic [2:0]  ent_dlv_mode,
  input  logic        ent_trig,
  input  logic        ent_dest_mode,
  input  logic        ent_redir,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [63:0] res_addr,
  output logic [31:0] res_data,
  output logic        res_err
);
  req_cls_e          cls;
  logic [IDX_W-1:0]  dec_index;
  logic [1:0]        dec_low;
  logic [1:0]        held_low;
  entry_t            ent;
  logic [ADDR_W-1:0] built_addr;
  logic [DATA_W-1:0] built_data;

  assign ent = '{dest: ent_dest, vector: ent_vector, dlv_mode: ent_dlv_mode,
                 trig: ent_trig, dest_mode: ent_dest_mode, redir: ent_redir};

  msi_req_decode u_dec (
    .enable   (remap_on),
    .addr     (in_addr),
    .data     (in_data),
    .cls      (cls),
    .index    (dec_index),
    .low_bits (dec_low)
  );

  msi_msg_build u_bld (
    .ent      (ent),
    .low_bits (held_low),
    .addr     (built_addr),
    .data     (built_data)
  );

  msi_remap_ctrl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .dec_cls    (cls),
    .dec_index  (dec_index),
    .dec_low    (dec_low),
    .lk_valid   (ent_req_valid),
    .lk_ready   (ent_req_ready),
    .lk_index   (ent_req_index),
    .rsp_valid  (ent_valid),
    .rsp_fault  (ent_fault),
    .built_addr (built_addr),
    .built_data (built_data),
    .held_low   (held_low),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_addr   (res_addr),
    .res_data   (res_data),
    .res_err    (res_err)
  );
endmodule

// File: rtl/msi_remap_chk.sv
module msi_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        ent_req_valid,
  input logic        ent_req_ready,
  input logic [15:0] ent_req_index,
  input logic        res_valid,
  input logic        res_ready,
  input logic [63:0] res_addr,
  input logic [31:0] res_data,
  input logic        res_err
);
  logic looked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            looked <= 1'b0;
    else if (in_valid && in_ready)         looked <= 1'b0;
    else if (ent_req_valid && ent_req_ready) looked <= 1'b1;
  end

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) &&
                                $stable(res_data) && $stable(res_err));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || ent_req_valid) |-> !in_ready);

  assert_lk_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ent_req_valid && !ent_req_ready |=> ent_req_valid && $stable(ent_req_index));

  assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> res_addr == 64'd0 && res_data == 32'd0);

  assert_remap_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_err && looked |->
      res_data[14] && res_data[31:16] == 16'd0 && res_data[13:11] == 3'd0);

  assert_remap_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_err && looked |->
      res_addr[31:20] == 12'hFEE && res_addr[11:4] == 8'd0 && res_addr[39:32] == 8'd0);
endmodule

bind msi_remap_xlate msi_remap_chk u_chk (.*);

// File: tb/sim_msi_remap_xlate.sv
module sim_msi_remap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        remap_on = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        ent_req_valid;
  logic        ent_req_ready = 1'b1;
  logic [15:0] ent_req_index;
  logic        ent_valid = 1'b0;
  logic        ent_fault = 1'b0;
  logic [31:0] ent_dest = '0;
  logic [7:0]  ent_vector = '0;
  logic [2:0]  ent_dlv_mode = '0;
  logic        ent_trig = 1'b0;
  logic        ent_dest_mode = 1'b0;
  logic        ent_redir = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_addr;
  logic [31:0] res_data;
  logic        res_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [63:0] q_addr[$];
  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];
  logic [15:0] q_idx[$];

  always #5 clk = ~clk;

  msi_remap_xlate u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Table model held by the bench's validator
  task automatic tbl(input logic [15:0] idx, output logic f, output logic [31:0] d,
                     output logic [7:0] v, output logic [2:0] dl, output logic tr,
                     output logic dm, output logic rh);
    f  = idx[15:12] == 4'hF;
    d  = {idx, ~idx};
    v  = idx[7:0] + 8'h20;
    dl = idx[4:2];
    tr = idx[5];
    dm = idx[0];
    rh = idx[1];
  endtask

  function automatic logic [63:0] mk(input logic [31:0] hi, input logic [11:0] head,
                                     input logic [14:0] lo, input logic fmt,
                                     input logic shv, input logic hib, input logic [1:0] lb);
    return {hi, head, lo, fmt, shv, hib, lb};
  endfunction

  // Driver: computes expected result, queues it, then presents the request
  task automatic send(input logic en, input logic [63:0] a, input logic [31:0] d,
                      input string tag);
    logic [63:0] ea; logic [31:0] ed; logic ee;
    logic [15:0] idx;
    logic f, tr, dm, rh; logic [31:0] dst; logic [7:0] v; logic [2:0] dl;
    ea = a; ed = d; ee = 1'b0;
    if (en) begin
      if (a[63:32] != 32'd0 || a[31:20] != 12'hFEE) begin
        ea = '0; ed = '0; ee = 1'b1;
      end else if (a[4]) begin
        if (a[3] && d[31:16] != 16'd0) begin
          ea = '0; ed = '0; ee = 1'b1;
        end else begin
          idx = {a[2], a[19:5]} + (a[3] ? d[15:0] : 16'd0);
          q_idx.push_back(idx);
          tbl(idx, f, dst, v, dl, tr, dm, rh);
          if (f) begin
            ea = '0; ed = '0; ee = 1'b1;
          end else begin
            ea = {dst[31:8], 8'h00, 12'hFEE, dst[7:0], 8'h00, rh, dm, a[1:0]};
            ed = {16'h0000, tr, 1'b1, 3'b000, dl, v};
          end
        end
      end
    end
    q_addr.push_back(ea); q_data.push_back(ed); q_err.push_back(ee); q_tag.push_back(tag);
    @(negedge clk);
    remap_on = en; in_addr = a; in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Validator model: checks the lookup index, answers two cycles later
  initial begin
    logic f, tr, dm, rh; logic [31:0] dst; logic [7:0] v; logic [2:0] dl;
    logic [15:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && ent_req_valid && ent_req_ready) begin
        if (q_idx.size() == 0) begin
          chk(1'b0, "R4", "unexpected lookup", {48'd0, ent_req_index}, 64'd0);
          e = ent_req_index;
        end else begin
          e = q_idx.pop_front();
          chk(ent_req_index == e, "R5", "lookup index", {48'd0, ent_req_index}, {48'd0, e});
        end
        tbl(ent_req_index, f, dst, v, dl, tr, dm, rh);
        @(negedge clk);
        ent_req_ready = 1'b0;
        @(negedge clk);
        ent_valid = 1'b1; ent_fault = f; ent_dest = dst; ent_vector = v;
        ent_dlv_mode = dl; ent_trig = tr; ent_dest_mode = dm; ent_redir = rh;
        @(negedge clk);
        ent_valid = 1'b0; ent_req_ready = 1'b1;
      end
    end
  end

  // Monitor: stalls the result port on a pattern and compares on handshake
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      res_ready = (cyc % 3) != 0;
      if (rst_n && res_valid && res_ready) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R11", "unexpected result", res_addr, 64'd0);
        end else begin
          logic [63:0] ea; logic [31:0] ed; logic ee; string tg;
          ea = q_addr.pop_front(); ed = q_data.pop_front();
          ee = q_err.pop_front();  tg = q_tag.pop_front();
          chk(res_err == ee, tg, "error flag", {63'd0, res_err}, {63'd0, ee});
          chk(res_addr == ea, tg, "address", res_addr, ea);
          chk(res_data == ed, tg, "data", {32'd0, res_data}, {32'd0, ed});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11", "reset in_ready", {63'd0, in_ready}, 64'd1);
    chk(res_valid == 1'b0, "R11", "reset res_valid", {63'd0, res_valid}, 64'd0);
    chk(ent_req_valid == 1'b0, "R11", "reset ent_req_valid", {63'd0, ent_req_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: disabled, even an illegal address passes through
    send(1'b0, 64'h1234_5678_0BAD_F00D, 32'hDEAD_BEEF, "R1");
    send(1'b0, mk(32'd0, 12'hFEE, 15'h0123, 1'b1, 1'b1, 1'b1, 2'b11), 32'hFFFF_0001, "R1");
    // R2: upper bits nonzero
    send(1'b1, mk(32'h0000_0001, 12'hFEE, 15'h0004, 1'b1, 1'b0, 1'b0, 2'b00), 32'h0, "R2");
    // R3: wrong head
    send(1'b1, mk(32'd0, 12'hFED, 15'h0004, 1'b1, 1'b0, 1'b0, 2'b00), 32'h0, "R3");
    send(1'b1, mk(32'd0, 12'h000, 15'h0000, 1'b0, 1'b0, 1'b0, 2'b00), 32'h0, "R3");
    // R4: compatibility layout passes through
    send(1'b1, mk(32'd0, 12'hFEE, 15'h7ABC, 1'b0, 1'b1, 1'b1, 2'b10), 32'hFFFF_4041, "R4");
    // R5: plain index, high bit clear and set, data ignored; R9/R10 layout
    send(1'b1, mk(32'd0, 12'hFEE, 15'h0123, 1'b1, 1'b0, 1'b0, 2'b01), 32'hFFFF_FFFF, "R5");
    send(1'b1, mk(32'd0, 12'hFEE, 15'h0456, 1'b1, 1'b0, 1'b1, 2'b10), 32'h0, "R9");
    send(1'b1, mk(32'd0, 12'hFEE, 15'h02A5, 1'b1, 1'b0, 1'b0, 2'b11), 32'h0, "R10");
    // R6: subhandle added, including wrap past 0xFFFF
    send(1'b1, mk(32'd0, 12'hFEE, 15'h0010, 1'b1, 1'b1, 1'b0, 2'b00), 32'h0000_0025, "R6");
    send(1'b1, mk(32'd0, 12'hFEE, 15'h7FFF, 1'b1, 1'b1, 1'b1, 2'b01), 32'h0000_0001, "R6");
    // R7: subhandle with reserved data bits
    send(1'b1, mk(32'd0, 12'hFEE, 15'h0010, 1'b1, 1'b1, 1'b0, 2'b00), 32'h0001_0000, "R7");
    // R8: faulting entries (index top nibble 0xF); R12 zeroed output
    send(1'b1, mk(32'd0, 12'hFEE, 15'h7000, 1'b1, 1'b0, 1'b1, 2'b11), 32'h0, "R8");
    send(1'b1, mk(32'd0, 12'hFEE, 15'h6FF0, 1'b1, 1'b1, 1'b1, 2'b00), 32'h0000_0100, "R12");
    // back-to-back traffic under the stall pattern
    for (int i = 0; i < 20; i++)
      send(1'b1, mk(32'd0, 12'hFEE, 15'(i * 37), 1'b1, 1'(i[0]), 1'(i[1]), 2'(i)),
           32'(i * 5), "R11");

    while (q_addr.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q_idx.size() == 0, "R5", "missing lookups", 64'(q_idx.size()), 64'd0);
    chk(in_ready == 1'b1, "R11", "idle in_ready", {63'd0, in_ready}, 64'd1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule